// File: doc/BRIEF.md
# History-indexed indirect target predictor

This block predicts the destination of an indirect call. Unlike a plain target buffer that keeps one destination per call site, it can keep several destinations for the same call site and picks between them using the recent global control-flow history. The lookup key combines the low source address bits with an XOR-compressed form of the history value. The history register is outside the block; the caller hands its current value in with every lookup.

A lookup produces a response one cycle later. On a hit the response carries the stored 48-bit target. On a miss it raises `use_fallback`, telling the front end to take its prediction from the simpler one-target-per-source buffer. When the branch resolves and the prediction was wrong or missing, the caller writes the resolved target through the update port. That write fills a slot in a 4-way, 64-set table, and a tree pseudo-LRU policy chooses which slot is replaced.

Lookups use a valid/ready stream. A lookup is accepted on a clock edge where `lk_valid` and `lk_ready` are both high. Its response is offered with `rsp_valid` and is consumed on an edge where `rsp_ready` is high. While `rsp_valid` is high and `rsp_ready` is low, the response is held unchanged and `lk_ready` is low, so back-pressure passes straight through the one-entry response stage. The update port is a plain control input and is never stalled.

Top module: `ipred_indirect_predictor`

## Requirements
- R1: The set index is computed in three steps. First, `lk_hist` (58 bits) is folded to 12 bits: bit j of the result is the XOR of every history bit i with i mod 12 == j. Second, that 12-bit value is XORed with `lk_src[11:0]` to form the key. Third, the key is folded the same way to 6 bits (bit j is the XOR of key bits i with i mod 6 == j), and the result is the set number 0..63.
- R2: The stored tag is 10 bits. It is the 10-bit fold of the history (bit j is the XOR of history bits i with i mod 10 == j), XORed with `lk_src[11:2]`. A lookup hits only on a valid way in its set whose tag is equal.
- R3: On a hit, the response has `pred_valid`=1, `use_fallback`=0, and `pred_target` equal to the target last written for that set and tag.
- R4: On a miss, the response has `use_fallback`=1, `pred_valid`=0 and `pred_target`=0.
- R5: One source address can hold up to 4 different targets at once, one per distinct history key. Each target is returned only under its own history.
- R6: An update is applied only on an edge where `upd_valid` and `upd_mispredict` are both 1. When `upd_valid` is 1 with `upd_mispredict` 0, the table and the replacement state are left unchanged.
- R7: An applied update whose set and tag already exist overwrites that way's target in place. No second copy of the entry is made.
- R8: An applied update that misses its set chooses a way in this order. The lowest-numbered invalid way is used if there is one. Otherwise the pseudo-LRU victim is used: 3 bits per set, where bit0 set means the victim is in ways 2..3, bit1 picks way 1 over way 0, and bit2 picks way 3 over way 2. A lookup hit, or an applied update, touches its way: on the path to that way, each bit is set to point away from it. Within one cycle, the lookup's touch is applied first and the update's touch second.
- R9: The response to a lookup accepted on edge k is visible after edge k. It reflects the table as it stood before any update applied on that same edge.
- R10: `lk_ready` equals NOT `rsp_valid` OR `rsp_ready`. While `rsp_valid` is 1 and `rsp_ready` is 0, the response outputs stay unchanged.
- R11: After reset, every way is invalid, all pseudo-LRU bits are 0, `rsp_valid` is 0 and `lk_ready` is 1.
- R12: When `rsp_valid` is 0, both `pred_valid` and `use_fallback` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_ready | output | 1 | Lookup can be accepted this edge |
| lk_src | input | 12 | Low source address bits of the indirect call |
| lk_hist | input | 58 | Current global history value |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response this edge |
| pred_valid | output | 1 | Response is a hit |
| pred_target | output | 48 | Predicted target (0 on a miss) |
| use_fallback | output | 1 | Response is a miss; use the single-target buffer |
| upd_valid | input | 1 | Resolved branch information present |
| upd_mispredict | input | 1 | Branch was mispredicted or missed; write it |
| upd_src | input | 12 | Low source address bits of the resolved call |
| upd_hist | input | 58 | History value the resolved call was looked up with |
| upd_target | input | 48 | Resolved target |

## Verification
Each response is due on the cycle after the edge that accepts its lookup, and it stays until the edge on which `rsp_ready` is high. The bench drives every input half a period before an edge. It keeps a one-deep expected response computed from a bench-side table model at acceptance time. It compares that response only on a cycle where the port shows `rsp_valid` and the bench is asserting `rsp_ready`. Updates take effect at the same edge but are seen only by later lookups, so the model applies a cycle's lookup before its update, in the order R9 gives.

// File: rtl/ipred_pkg.sv
package ipred_pkg;
  localparam int DEF_SRC_W  = 12;
  localparam int DEF_HIST_W = 58;
  localparam int DEF_TGT_W  = 48;
  localparam int DEF_SETS   = 64;
  localparam int DEF_WAYS   = 4;
  localparam int DEF_TAG_W  = 10;
endpackage

// File: rtl/ipred_hash.sv
module ipred_hash #(
  parameter int SRC_W  = ipred_pkg::DEF_SRC_W,
  parameter int HIST_W = ipred_pkg::DEF_HIST_W,
  parameter int IDX_W  = 6,
  parameter int TAG_W  = ipred_pkg::DEF_TAG_W
) (
  input  logic [SRC_W-1:0]  src,
  input  logic [HIST_W-1:0] hist,
  output logic [IDX_W-1:0]  set_idx,
  output logic [TAG_W-1:0]  tag
);
  logic [SRC_W-1:0] hfold_key;
  logic [SRC_W-1:0] key;
  logic [TAG_W-1:0] hfold_tag;

  // Fold history into key width and tag width by XOR of consecutive slices
  always_comb begin
    hfold_key = '0;
    hfold_tag = '0;
    for (int i = 0; i < HIST_W; i++) begin
      hfold_key[i % SRC_W] = hfold_key[i % SRC_W] ^ hist[i];
      hfold_tag[i % TAG_W] = hfold_tag[i % TAG_W] ^ hist[i];
    end
  end

  assign key = hfold_key ^ src;

  // Key is folded again down to the set index width
  always_comb begin
    set_idx = '0;
    for (int i = 0; i < SRC_W; i++) begin
      set_idx[i % IDX_W] = set_idx[i % IDX_W] ^ key[i];
    end
  end

  assign tag = hfold_tag ^ src[SRC_W-1 -: TAG_W];
endmodule

// File: rtl/ipred_match.sv
module ipred_match #(
  parameter int WAYS  = ipred_pkg::DEF_WAYS,
  parameter int TAG_W = ipred_pkg::DEF_TAG_W,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            way_vld,
  input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [TAG_W-1:0]           tag,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way
);
  logic [WAYS-1:0] eq;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign eq[w] = way_vld[w] && (way_tag[w] == tag);
  end

  assign hit = |eq;

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (eq[w]) hit_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/ipred_plru_touch.sv
module ipred_plru_touch #(
  parameter int WAYS = ipred_pkg::DEF_WAYS,
  localparam int WAY_W = $clog2(WAYS),
  localparam int PL_W  = WAYS - 1
) (
  input  logic [PL_W-1:0]  state,
  input  logic [WAY_W-1:0] way,
  output logic [PL_W-1:0]  next_state
);
  // Walk root to leaf; each node on the path points away from the touched way
  always_comb begin
    int  node;
    int  lo;
    int  span;
    int  half;
    logic dir;
    next_state = state;
    node = 0;
    lo   = 0;
    span = WAYS;
    for (int l = 0; l < WAY_W; l++) begin
      half = span / 2;
      dir  = (int'(way) >= lo + half);
      next_state[node] = !dir;
      if (dir) lo = lo + half;
      node = 2 * node + 1 + (dir ? 1 : 0);
      span = half;
    end
  end
endmodule

// File: rtl/ipred_victim.sv
module ipred_victim #(
  parameter int WAYS = ipred_pkg::DEF_WAYS,
  localparam int WAY_W = $clog2(WAYS),
  localparam int PL_W  = WAYS - 1
) (
  input  logic [WAYS-1:0]  way_vld,
  input  logic [PL_W-1:0]  state,
  output logic [WAY_W-1:0] fill_way
);
  logic [WAY_W-1:0] tree_way;

  // Follow the pointer bits from root to the least recently used leaf
  always_comb begin
    int node;
    int lo;
    int span;
    int half;
    node = 0;
    lo   = 0;
    span = WAYS;
    for (int l = 0; l < WAY_W; l++) begin
      half = span / 2;
      if (state[node]) lo = lo + half;
      node = 2 * node + 1 + (state[node] ? 1 : 0);
      span = half;
    end
    tree_way = WAY_W'(lo);
  end

  // The lowest invalid way takes priority over the tree choice
  always_comb begin
    fill_way = tree_way;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!way_vld[w]) fill_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/ipred_indirect_predictor.sv
module ipred_indirect_predictor #(
  parameter int SRC_W  = ipred_pkg::DEF_SRC_W,
  parameter int HIST_W = ipred_pkg::DEF_HIST_W,
  parameter int TGT_W  = ipred_pkg::DEF_TGT_W,
  parameter int SETS   = ipred_pkg::DEF_SETS,
  parameter int WAYS   = ipred_pkg::DEF_WAYS,
  parameter int TAG_W  = ipred_pkg::DEF_TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [SRC_W-1:0]  lk_src,
  input  logic [HIST_W-1:0] lk_hist,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              pred_valid,
  output logic [TGT_W-1:0]  pred_target,
  output logic              use_fallback,
  input  logic              upd_valid,
  input  logic              upd_mispredict,
  input  logic [SRC_W-1:0]  upd_src,
  input  logic [HIST_W-1:0] upd_hist,
  input  logic [TGT_W-1:0]  upd_target
);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int PL_W  = WAYS - 1;

  // Table storage
  logic [WAYS-1:0]            vld_q  [SETS];
  logic [WAYS-1:0][TAG_W-1:0] tag_q  [SETS];
  logic [TGT_W-1:0]           tgt_q  [SETS][WAYS];
  logic [PL_W-1:0]            plru_q [SETS];

  // Response stage
  logic             rsp_hit_q;
  logic [TGT_W-1:0] rsp_tgt_q;

  // Lookup side
  logic [IDX_W-1:0] lk_set;
  logic [TAG_W-1:0] lk_tag;
  logic             lk_hit;
  logic [WAY_W-1:0] lk_way;
  logic             lk_accept;
  logic             lk_touch;
  logic [PL_W-1:0]  lk_plru_next;

  // Update side
  logic [IDX_W-1:0] upd_set;
  logic [TAG_W-1:0] upd_tag;
  logic             upd_hit;
  logic [WAY_W-1:0] upd_hit_way;
  logic [WAY_W-1:0] upd_fill_way;
  logic [WAY_W-1:0] upd_way;
  logic             upd_do;
  logic [PL_W-1:0]  upd_plru_base;
  logic [PL_W-1:0]  upd_plru_next;

  ipred_hash #(.SRC_W(SRC_W), .HIST_W(HIST_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) i_hash_lk (
    .src(lk_src), .hist(lk_hist), .set_idx(lk_set), .tag(lk_tag)
  );

  ipred_hash #(.SRC_W(SRC_W), .HIST_W(HIST_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) i_hash_upd (
    .src(upd_src), .hist(upd_hist), .set_idx(upd_set), .tag(upd_tag)
  );

  ipred_match #(.WAYS(WAYS), .TAG_W(TAG_W)) i_match_lk (
    .way_vld(vld_q[lk_set]), .way_tag(tag_q[lk_set]), .tag(lk_tag),
    .hit(lk_hit), .hit_way(lk_way)
  );

  ipred_match #(.WAYS(WAYS), .TAG_W(TAG_W)) i_match_upd (
    .way_vld(vld_q[upd_set]), .way_tag(tag_q[upd_set]), .tag(upd_tag),
    .hit(upd_hit), .hit_way(upd_hit_way)
  );

  assign lk_ready  = !rsp_valid || rsp_ready;
  assign lk_accept = lk_valid && lk_ready;
  assign lk_touch  = lk_accept && lk_hit;
  assign upd_do    = upd_valid && upd_mispredict;

  ipred_plru_touch #(.WAYS(WAYS)) i_touch_lk (
    .state(plru_q[lk_set]), .way(lk_way), .next_state(lk_plru_next)
  );

  // The update sees the lookup's touch when both land in one set this cycle
  assign upd_plru_base = (lk_touch && (lk_set == upd_set)) ? lk_plru_next
                                                           : plru_q[upd_set];

  ipred_victim #(.WAYS(WAYS)) i_victim (
    .way_vld(vld_q[upd_set]), .state(upd_plru_base), .fill_way(upd_fill_way)
  );

  assign upd_way = upd_hit ? upd_hit_way : upd_fill_way;

  ipred_plru_touch #(.WAYS(WAYS)) i_touch_upd (
    .state(upd_plru_base), .way(upd_way), .next_state(upd_plru_next)
  );

  // Control state with reset
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s]  <= '0;
        plru_q[s] <= '0;
      end
      rsp_valid <= 1'b0;
      rsp_hit_q <= 1'b0;
      rsp_tgt_q <= '0;
    end else begin
      if (lk_accept) begin
        rsp_valid <= 1'b1;
        rsp_hit_q <= lk_hit;
        rsp_tgt_q <= lk_hit ? tgt_q[lk_set][lk_way] : '0;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
      if (lk_touch) begin
        plru_q[lk_set] <= lk_plru_next;
      end
      if (upd_do) begin
        vld_q[upd_set][upd_way] <= 1'b1;
        plru_q[upd_set]         <= upd_plru_next;
      end
    end
  end

  // Payload storage needs no reset: it is qualified by the valid bits
  always_ff @(posedge clk) begin
    if (upd_do) begin
      tag_q[upd_set][upd_way] <= upd_tag;
      tgt_q[upd_set][upd_way] <= upd_target;
    end
  end

  assign pred_valid   = rsp_valid && rsp_hit_q;
  assign use_fallback = rsp_valid && !rsp_hit_q;
  assign pred_target  = rsp_tgt_q;
endmodule

// File: rtl/ipred_checks.sv
module ipred_checks #(
  parameter int TGT_W = ipred_pkg::DEF_TGT_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic             lk_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             pred_valid,
  input logic [TGT_W-1:0] pred_target,
  input logic             use_fallback
);
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (pred_valid != use_fallback)); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!pred_valid && !use_fallback)); // R12

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    use_fallback |-> (pred_target == '0)); // R4

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(pred_target)
                                   && $stable(pred_valid))); // R10

  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !lk_ready); // R10

  AST_ACCEPT_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> rsp_valid); // R9

  AST_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready && !lk_valid) |=> !rsp_valid); // R9
endmodule

bind ipred_indirect_predictor ipred_checks #(.TGT_W(TGT_W)) i_ipred_checks (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .pred_valid(pred_valid),
  .pred_target(pred_target), .use_fallback(use_fallback)
);

// File: tb/test_ipred_indirect_predictor.sv
`timescale 1ns/1ps
module test_ipred_indirect_predictor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [11:0] lk_src = '0;
  logic [57:0] lk_hist = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic        pred_valid;
  logic [47:0] pred_target;
  logic        use_fallback;
  logic        upd_valid = 1'b0;
  logic        upd_mispredict = 1'b0;
  logic [11:0] upd_src = '0;
  logic [57:0] upd_hist = '0;
  logic [47:0] upd_target = '0;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2.5 clk = !clk;

  ipred_indirect_predictor i_ipred_indirect_predictor (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .lk_src(lk_src), .lk_hist(lk_hist), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .pred_valid(pred_valid), .pred_target(pred_target),
    .use_fallback(use_fallback), .upd_valid(upd_valid),
    .upd_mispredict(upd_mispredict), .upd_src(upd_src), .upd_hist(upd_hist),
    .upd_target(upd_target)
  );

  // Reference table model
  bit          m_vld  [64][4];
  logic [9:0]  m_tag  [64][4];
  logic [47:0] m_tgt  [64][4];
  bit [2:0]    m_plru [64];
  bit          e_pend;
  bit          e_hit;
  logic [47:0] e_tgt;
  string       e_ctx;

  function automatic logic [63:0] b_fold(input logic [63:0] v, input int n, input int f);
    logic [63:0] r = '0;
    for (int i = 0; i < n; i++) r[i % f] = r[i % f] ^ v[i];
    return r;
  endfunction

  function automatic int b_set(input logic [11:0] s, input logic [57:0] h);
    logic [63:0] k;
    logic [63:0] q;
    k = {52'd0, b_fold({6'd0, h}, 58, 12)[11:0] ^ s};
    q = b_fold(k, 12, 6);
    return int'(q[5:0]);
  endfunction

  function automatic logic [9:0] b_tag(input logic [11:0] s, input logic [57:0] h);
    logic [63:0] q;
    q = b_fold({6'd0, h}, 58, 10);
    return q[9:0] ^ s[11:2];
  endfunction

  function automatic int b_victim(input bit [2:0] st);
    if (st[0]) return st[2] ? 3 : 2;
    return st[1] ? 1 : 0;
  endfunction

  function automatic bit [2:0] b_touch(input bit [2:0] st, input int w);
    bit [2:0] r = st;
    r[0] = (w < 2);
    if (w < 2) r[1] = (w == 0);
    else       r[2] = (w == 2);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check, advance model, cross the edge
  task automatic step(input string ctx, input bit lv, input logic [11:0] ls,
                      input logic [57:0] lh, input bit rr, input bit uv,
                      input bit um, input logic [11:0] us, input logic [57:0] uh,
                      input logic [47:0] ut);
    bit acc;
    int s;
    int w;
    logic [9:0] t;
    lk_valid = lv; lk_src = ls; lk_hist = lh; rsp_ready = rr;
    upd_valid = uv; upd_mispredict = um; upd_src = us; upd_hist = uh;
    upd_target = ut;
    #1;
    chk(rsp_valid == e_pend, "R9", "rsp_valid", 64'(rsp_valid), 64'(e_pend));
    chk(lk_ready == (!e_pend || rr), "R10", "lk_ready", 64'(lk_ready),
        64'(!e_pend || rr));
    if (!e_pend) begin
      chk(!pred_valid && !use_fallback, "R12", "idle flags",
          64'({pred_valid, use_fallback}), 64'd0);
    end else if (rr) begin
      chk(pred_valid == e_hit, e_ctx, "pred_valid (R3)", 64'(pred_valid), 64'(e_hit));
      chk(use_fallback == !e_hit, e_ctx, "use_fallback (R4)", 64'(use_fallback),
          64'(!e_hit));
      chk(pred_target == e_tgt, e_ctx, "pred_target", 64'(pred_target), 64'(e_tgt));
    end
    acc = lv && (!e_pend || rr);
    if (acc) begin
      s = b_set(ls, lh); t = b_tag(ls, lh);
      e_hit = 1'b0; e_tgt = '0; e_ctx = ctx;
      for (int k = 3; k >= 0; k--) if (m_vld[s][k] && m_tag[s][k] == t) w = k;
      for (int k = 0; k < 4; k++) if (m_vld[s][k] && m_tag[s][k] == t) e_hit = 1'b1;
      if (e_hit) begin
        e_tgt = m_tgt[s][w];
        m_plru[s] = b_touch(m_plru[s], w);
      end
      e_pend = 1'b1;
    end else if (rr) begin
      e_pend = 1'b0;
    end
    if (uv && um) begin
      bit h = 1'b0;
      bit fnd = 1'b0;
      s = b_set(us, uh); t = b_tag(us, uh);
      for (int k = 3; k >= 0; k--) if (m_vld[s][k] && m_tag[s][k] == t) begin w = k; h = 1'b1; end
      if (!h) begin
        for (int k = 3; k >= 0; k--) if (!m_vld[s][k]) begin w = k; fnd = 1'b1; end
        if (!fnd) w = b_victim(m_plru[s]);
      end
      m_vld[s][w] = 1'b1; m_tag[s][w] = t; m_tgt[s][w] = ut;
      m_plru[s] = b_touch(m_plru[s], w);
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic look(input string ctx, input logic [11:0] s, input logic [57:0] h);
    step(ctx, 1'b1, s, h, 1'b1, 1'b0, 1'b0, '0, '0, '0);
  endtask

  task automatic put(input string ctx, input bit um, input logic [11:0] s,
                     input logic [57:0] h, input logic [47:0] t);
    step(ctx, 1'b0, '0, '0, 1'b1, 1'b1, um, s, h, t);
  endtask

  task automatic idle(input string ctx);
    step(ctx, 1'b0, '0, '0, 1'b1, 1'b0, 1'b0, '0, '0, '0);
  endtask

  function automatic logic [57:0] rnd_hist();
    return {$urandom, $urandom}[57:0];
  endfunction

  function automatic logic [47:0] rnd_tgt();
    return {$urandom, $urandom}[47:0];
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL R9 watchdog: actual %0d cycles expected fewer", 200000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin : main
    logic [57:0] hs [5];
    logic [57:0] hpool [8];
    logic [11:0] spool [4];
    logic [57:0] h0;
    logic [11:0] sa;
    logic [11:0] sb;
    int tset;
    int found;
    void'($urandom(32'd20240611));
    for (int s = 0; s < 64; s++) begin
      m_plru[s] = '0;
      for (int w = 0; w < 4; w++) m_vld[s][w] = 1'b0;
    end
    e_pend = 1'b0; e_hit = 1'b0; e_tgt = '0; e_ctx = "R11";

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11: reset state at the ports
    chk(rsp_valid == 1'b0, "R11", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
    chk(lk_ready == 1'b1, "R11", "lk_ready after reset", 64'(lk_ready), 64'd1);
    chk(!pred_valid && !use_fallback, "R11", "flags after reset",
        64'({pred_valid, use_fallback}), 64'd0);
    @(negedge clk);

    sa = 12'h5a3; h0 = rnd_hist();
    look("R11", sa, h0);               // empty table: miss
    put("R6", 1'b0, sa, h0, 48'h1234_5678_9abc);
    look("R6", sa, h0);                // ignored update: still miss
    put("R3", 1'b1, sa, h0, 48'h1234_5678_9abc);
    look("R3", sa, h0);
    idle("R3");

    // R5: same source, several histories, several targets
    for (int i = 0; i < 3; i++) begin
      hs[i] = rnd_hist();
      put("R5", 1'b1, sa, hs[i], rnd_tgt());
    end
    for (int i = 0; i < 3; i++) look("R5", sa, hs[i]);
    look("R5", sa, h0);

    // R7: overwrite in place
    put("R7", 1'b1, sa, h0, 48'hfeed_0000_beef);
    look("R7", sa, h0);
    for (int i = 0; i < 3; i++) look("R7", sa, hs[i]);

    // R1/R2/R8: five keys in one set with distinct tags
    sb = 12'h0c7;
    hs[0] = rnd_hist();
    tset = b_set(sb, hs[0]);
    found = 1;
    for (int tries = 0; tries < 20000 && found < 5; tries++) begin
      logic [57:0] c;
      bit dup;
      c = rnd_hist();
      dup = 1'b0;
      for (int j = 0; j < found; j++) if (b_tag(sb, c) == b_tag(sb, hs[j])) dup = 1'b1;
      if (b_set(sb, c) == tset && !dup) begin
        hs[found] = c;
        found++;
      end
    end
    chk(found == 5, "R2", "same-set key search", 64'(found), 64'd5);
    for (int i = 0; i < 4; i++) put("R8", 1'b1, sb, hs[i], rnd_tgt());
    look("R8", sb, hs[0]);
    look("R8", sb, hs[2]);
    put("R8", 1'b1, sb, hs[4], rnd_tgt());
    for (int i = 0; i < 5; i++) look("R2", sb, hs[i]);
    put("R8", 1'b1, sb, hs[1], rnd_tgt());
    for (int i = 0; i < 5; i++) look("R8", sb, hs[i]);

    // R9: lookup and update of an absent key on the same edge
    h0 = rnd_hist();
    step("R9", 1'b1, 12'h321, h0, 1'b1, 1'b1, 1'b1, 12'h321, h0, 48'h0abc_def0_1234);
    look("R9", 12'h321, h0);

    // R10: hold the response under back-pressure
    step("R10", 1'b1, sa, hs[0], 1'b0, 1'b0, 1'b0, '0, '0, '0);
    step("R10", 1'b1, sb, hs[4], 1'b0, 1'b0, 1'b0, '0, '0, '0);
    step("R10", 1'b1, sb, hs[4], 1'b0, 1'b0, 1'b0, '0, '0, '0);
    step("R10", 1'b1, sb, hs[4], 1'b1, 1'b0, 1'b0, '0, '0, '0);
    idle("R10");

    // Random mix over a small key pool (R1)
    for (int i = 0; i < 4; i++) spool[i] = 12'($urandom);
    for (int i = 0; i < 8; i++) hpool[i] = rnd_hist();
    for (int n = 0; n < 4000; n++) begin
      step("R1", ($urandom % 4) != 0, spool[$urandom % 4], hpool[$urandom % 8],
           ($urandom % 4) != 0, ($urandom % 3) == 0, ($urandom % 4) != 0,
           spool[$urandom % 4], hpool[$urandom % 8], rnd_tgt());
    end
    idle("R1");
    idle("R1");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule